// File: doc/BRIEF.md
# Dual Bridge PCI Configuration Header

This block holds the configuration registers of two single-function PCI devices on one die: a host bridge and an ISA bridge. Each device owns a 256-byte register file. It comes out of reset with fixed identification bytes and applies a fixed write rule to every offset. Depending on the offset, a written byte is dropped, masked, replaced by a constant, or stored in full.

Access uses a plain byte strobe interface. The caller supplies the device select, the function number, the offset and, for writes, the data. Only function 0 exists. Any other function number reads back 0xFF and cannot change state. Read data is registered and comes back one cycle after the read strobe, together with a valid flag.

Top module: `pci_bridge_cfg`

## Requirements
- R1: After reset both devices read vendor bytes 0x4A/0x10 at offsets 0x00/0x01, command 0x07 at 0x04, status bytes 0x80/0x02 at 0x06/0x07 and base class 0x06 at 0x0B. The host bridge reads device ID bytes 0x0A/0x02 at 0x02/0x03. The ISA bridge reads 0x10/0x02 at 0x02/0x03, subclass 0x01 at 0x0A and header type 0x40 at 0x0E. Every other offset reads 0x00.
- R2: Writes to offsets 0x00 through 0x04, 0x08 through 0x0B, 0x0E and 0x54 leave the stored byte unchanged.
- R3: A write to offset 0x05 stores only bit 0 of the data and clears bits 7:1.
- R4: A write to offset 0x06 stores 0x00 and a write to offset 0x07 stores 0x02, whatever the data.
- R5: In the host bridge, a write to offset 0x50 stores data AND 0x1F and a write to offset 0x52 stores data AND 0x70. In the ISA bridge those two offsets store the full byte.
- R6: A write to any offset not named in R2 to R5 stores the full data byte.
- R7: When the function number is not 0, a read returns 0xFF and a write changes no register.
- R8: rvalid_o is high exactly in the cycle after a cycle with rd_i high, and rdata_o is valid in that cycle. rvalid_o is low during and straight after reset.
- R9: sel_i = 0 addresses the host bridge and sel_i = 1 addresses the ISA bridge. An access to one device never changes the other.
- R10: When rd_i and wr_i are both high in one cycle at the same offset, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Device select: 0 host bridge, 1 ISA bridge |
| func_i | input | FUNC_W | Function number of the access |
| addr_i | input | 8 | Register offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |

## Verification
The hardest cases to reach from the ports are the ones where nothing changes. These are a write to a read-only offset, a write on a nonzero function number, and a write to the device that is not selected. None of them shows up at the output unless a later read looks at exactly that byte. The stimulus therefore follows each such write with readback of the target offset on both devices. A full sweep writes an offset-dependent pattern to all 256 offsets of both bridges and then reads every byte back, so a stray or misdirected write cannot hide. Same-cycle read and write at one offset is driven by raising both strobes together, and the returned byte is compared against the value held before the write.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int CFG_AW    = 8;
  localparam int CFG_DEPTH = 1 << CFG_AW;

  typedef enum logic [1:0] {
    WP_FULL  = 2'd0,
    WP_RO    = 2'd1,
    WP_MASK  = 2'd2,
    WP_CONST = 2'd3
  } wpol_e;

  typedef struct packed {
    wpol_e      kind;
    logic [7:0] val;
  } wrule_t;

  function automatic wrule_t rule_for(input logic [7:0] off, input logic ext_masks);
    wrule_t r;
    r.kind = WP_FULL;
    r.val  = 8'hFF;
    case (off)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0E, 8'h54: r.kind = WP_RO;
      8'h05: begin r.kind = WP_MASK;  r.val = 8'h01; end
      8'h06: begin r.kind = WP_CONST; r.val = 8'h00; end
      8'h07: begin r.kind = WP_CONST; r.val = 8'h02; end
      8'h50: if (ext_masks) begin r.kind = WP_MASK; r.val = 8'h1F; end
      8'h52: if (ext_masks) begin r.kind = WP_MASK; r.val = 8'h70; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] reset_byte(input logic [7:0] off, input logic [15:0] vendor,
                                            input logic [15:0] dev_id, input logic [7:0] base_cls,
                                            input logic [7:0] sub_cls, input logic [7:0] hdr);
    logic [7:0] v;
    case (off)
      8'h00:   v = vendor[7:0];
      8'h01:   v = vendor[15:8];
      8'h02:   v = dev_id[7:0];
      8'h03:   v = dev_id[15:8];
      8'h04:   v = 8'h07;
      8'h06:   v = 8'h80;
      8'h07:   v = 8'h02;
      8'h0A:   v = sub_cls;
      8'h0B:   v = base_cls;
      8'h0E:   v = hdr;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pci_cfg_wpolicy.sv
module pci_cfg_wpolicy
  import pci_cfg_pkg::*;
#(
  parameter bit EXT_MASKS = 1'b1
) (
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              store_o,
  output logic [7:0]        sdata_o
);
  wrule_t rule;

  always_comb begin
    rule    = rule_for(addr_i, EXT_MASKS);
    store_o = (rule.kind != WP_RO);
    case (rule.kind)
      WP_MASK:  sdata_o = wdata_i & rule.val;
      WP_CONST: sdata_o = rule.val;
      default:  sdata_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/pci_cfg_regfile.sv
module pci_cfg_regfile
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h104A,
  parameter logic [15:0] DEV_ID    = 16'h020A,
  parameter logic [7:0]  BASE_CLS  = 8'h06,
  parameter logic [7:0]  SUB_CLS   = 8'h00,
  parameter logic [7:0]  HDR_TYPE  = 8'h00
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CFG_AW-1:0]             waddr_i,
  input  logic [7:0]                    wdata_i,
  output logic [CFG_DEPTH-1:0][7:0]     mem_o
);
  for (genvar i = 0; i < CFG_DEPTH; i++) begin : g_byte
    localparam logic [CFG_AW-1:0] OFF = CFG_AW'(i);
    localparam logic [7:0] RV = reset_byte(OFF, VENDOR_ID, DEV_ID, BASE_CLS, SUB_CLS, HDR_TYPE);
    logic [7:0] byte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      byte_q <= RV;
      else if (we_i && waddr_i == OFF)  byte_q <= wdata_i;
    end

    assign mem_o[i] = byte_q;
  end
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_pkg::*;
#(
  parameter int          FUNC_W    = 3,
  parameter logic [15:0] VENDOR_ID = 16'h104A,
  parameter logic [15:0] DEV_ID    = 16'h020A,
  parameter logic [7:0]  BASE_CLS  = 8'h06,
  parameter logic [7:0]  SUB_CLS   = 8'h00,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter bit          EXT_MASKS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o
);
  logic                      fn0;
  logic                      store;
  logic [7:0]                sdata;
  logic [CFG_DEPTH-1:0][7:0] mem;
  logic [7:0]                rdata_q;
  logic                      rvalid_q;

  assign fn0 = (func_i == '0);

  pci_cfg_wpolicy #(.EXT_MASKS(EXT_MASKS)) u_pol (
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .store_o (store),
    .sdata_o (sdata)
  );

  pci_cfg_regfile #(
    .VENDOR_ID (VENDOR_ID),
    .DEV_ID    (DEV_ID),
    .BASE_CLS  (BASE_CLS),
    .SUB_CLS   (SUB_CLS),
    .HDR_TYPE  (HDR_TYPE)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && fn0 && store),
    .waddr_i (addr_i),
    .wdata_i (sdata),
    .mem_o   (mem)
  );

  // read sees pre-write contents when strobes coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= fn0 ? mem[addr_i] : 8'hFF;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R8
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  // R7
  fn_absent_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && func_i != '0) |=> rdata_o == 8'hFF);
  // R7
  fn_absent_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && func_i != '0) |=> $stable(mem));
  // R2
  ident_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mem[3:0]) && $stable(mem[11:8]) && $stable(mem[14]) && $stable(mem[84]));
  // R3
  cmd_hi_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem[5][7:1] == 7'd0);
  // R4
  status_hi_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && fn0 && addr_i == 8'h07) |=> mem[7] == 8'h02);
  // R10
  rw_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i && fn0) |=> rdata_o == $past(mem[addr_i]));
endmodule

// File: rtl/pci_bridge_cfg.sv
module pci_bridge_cfg #(
  parameter int          FUNC_W       = 3,
  parameter logic [15:0] VENDOR_ID    = 16'h104A,
  parameter logic [15:0] HOST_DEV_ID  = 16'h020A,
  parameter logic [15:0] ISA_DEV_ID   = 16'h0210,
  parameter logic [7:0]  BRIDGE_CLASS = 8'h06,
  parameter logic [7:0]  ISA_SUB_CLS  = 8'h01,
  parameter logic [7:0]  ISA_HDR_TYPE = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [7:0]        addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o
);
  localparam int NDEV = 2;

  logic [NDEV-1:0]      dev_rvalid;
  logic [NDEV-1:0][7:0] dev_rdata;

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    localparam bit          IS_HOST = (k == 0);
    localparam logic [15:0] DID     = IS_HOST ? HOST_DEV_ID : ISA_DEV_ID;
    localparam logic [7:0]  SCLS    = IS_HOST ? 8'h00 : ISA_SUB_CLS;
    localparam logic [7:0]  HDR     = IS_HOST ? 8'h00 : ISA_HDR_TYPE;
    logic hit;

    assign hit = (sel_i == 1'(k));

    pci_cfg_header #(
      .FUNC_W    (FUNC_W),
      .VENDOR_ID (VENDOR_ID),
      .DEV_ID    (DID),
      .BASE_CLS  (BRIDGE_CLASS),
      .SUB_CLS   (SCLS),
      .HDR_TYPE  (HDR),
      .EXT_MASKS (IS_HOST)
    ) u_hdr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .func_i   (func_i),
      .addr_i   (addr_i),
      .wr_i     (wr_i && hit),
      .wdata_i  (wdata_i),
      .rd_i     (rd_i && hit),
      .rdata_o  (dev_rdata[k]),
      .rvalid_o (dev_rvalid[k])
    );
  end

  assign rvalid_o = |dev_rvalid;
  assign rdata_o  = dev_rvalid[1] ? dev_rdata[1] : dev_rdata[0];

  // R9
  one_responder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_rvalid));
  // R9
  sel_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> dev_rvalid[$past(sel_i)]);
endmodule

// File: tb/tb_pci_bridge_cfg.sv
module tb_pci_bridge_cfg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [2:0] func = 3'd0;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       rvalid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] model [2][256];
  logic [7:0] q_exp [$];
  string      q_req [$];

  always #2 clk = ~clk;

  pci_bridge_cfg dut (
    .clk_i (clk), .rst_ni (rst_n), .sel_i (sel), .func_i (func), .addr_i (addr),
    .wr_i (wr), .wdata_i (wdata), .rd_i (rd), .rdata_o (rdata), .rvalid_o (rvalid)
  );

  function automatic logic [7:0] rst_val(int d, int off);
    case (off)
      8'h00: return 8'h4A;
      8'h01: return 8'h10;
      8'h02: return d ? 8'h10 : 8'h0A;
      8'h03: return 8'h02;
      8'h04: return 8'h07;
      8'h06: return 8'h80;
      8'h07: return 8'h02;
      8'h0A: return d ? 8'h01 : 8'h00;
      8'h0B: return 8'h06;
      8'h0E: return d ? 8'h40 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  // expected stored byte after a function-0 write (R2..R6)
  function automatic logic [7:0] after_wr(int d, int off, logic [7:0] v, logic [7:0] old);
    if ((off <= 4) || (off >= 8 && off <= 11) || off == 14 || off == 8'h54) return old;
    if (off == 5) return v & 8'h01;
    if (off == 6) return 8'h00;
    if (off == 7) return 8'h02;
    if (d == 0 && off == 8'h50) return v & 8'h1F;
    if (d == 0 && off == 8'h52) return v & 8'h70;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(bit s, logic [2:0] f, logic [7:0] a, logic [7:0] v);
    @(negedge clk);
    sel = s; func = f; addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (f == 3'd0) model[s][a] = after_wr(int'(s), int'(a), v, model[s][a]);
  endtask

  task automatic do_read(bit s, logic [2:0] f, logic [7:0] a, string req);
    @(negedge clk);
    sel = s; func = f; addr = a; rd = 1'b1;
    q_exp.push_back((f != 3'd0) ? 8'hFF : model[s][a]);
    q_req.push_back(req);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_rw(bit s, logic [7:0] a, logic [7:0] v, string req);
    @(negedge clk);
    sel = s; func = 3'd0; addr = a; wdata = v; rd = 1'b1; wr = 1'b1;
    q_exp.push_back(model[s][a]);
    q_req.push_back(req);
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    model[s][a] = after_wr(int'(s), int'(a), v, model[s][a]);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R8 unexpected rvalid", rdata, 8'h00);
      end else begin
        automatic logic [7:0] e = q_exp.pop_front();
        automatic string r = q_req.pop_front();
        check(rdata === e, r, rdata, e);
      end
    end
  end

  initial begin
    #(50000 * 4);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 256; o++) model[d][o] = rst_val(d, o);

    repeat (3) @(negedge clk);
    check(rvalid === 1'b0, "R8 rvalid in reset", {7'd0, rvalid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(rvalid === 1'b0, "R8 rvalid after reset", {7'd0, rvalid}, 8'h00);

    // R1 reset identity on both devices
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 16; o++) do_read(d[0], 3'd0, 8'(o), "R1 reset value");
    do_read(1'b0, 3'd0, 8'h50, "R1 reset zero");
    do_read(1'b1, 3'd0, 8'hFF, "R1 reset zero");

    // R2 read-only offsets
    for (int d = 0; d < 2; d++) begin
      do_write(d[0], 3'd0, 8'h00, 8'hFF);
      do_write(d[0], 3'd0, 8'h03, 8'h55);
      do_write(d[0], 3'd0, 8'h04, 8'h00);
      do_write(d[0], 3'd0, 8'h0A, 8'hEE);
      do_write(d[0], 3'd0, 8'h0E, 8'h81);
      do_write(d[0], 3'd0, 8'h54, 8'h3C);
      do_read(d[0], 3'd0, 8'h00, "R2 ro 00");
      do_read(d[0], 3'd0, 8'h03, "R2 ro 03");
      do_read(d[0], 3'd0, 8'h04, "R2 ro 04");
      do_read(d[0], 3'd0, 8'h0A, "R2 ro 0A");
      do_read(d[0], 3'd0, 8'h0E, "R2 ro 0E");
      do_read(d[0], 3'd0, 8'h54, "R2 ro 54");
    end

    // R3, R4
    do_write(1'b0, 3'd0, 8'h05, 8'hFF); do_read(1'b0, 3'd0, 8'h05, "R3 cmd hi FF");
    do_write(1'b1, 3'd0, 8'h05, 8'hFE); do_read(1'b1, 3'd0, 8'h05, "R3 cmd hi FE");
    do_write(1'b0, 3'd0, 8'h06, 8'hFF); do_read(1'b0, 3'd0, 8'h06, "R4 status lo");
    do_write(1'b1, 3'd0, 8'h07, 8'h00); do_read(1'b1, 3'd0, 8'h07, "R4 status hi");
    do_write(1'b0, 3'd0, 8'h07, 8'hFD); do_read(1'b0, 3'd0, 8'h07, "R4 status hi");

    // R5 device-specific masks
    do_write(1'b0, 3'd0, 8'h50, 8'hFF); do_read(1'b0, 3'd0, 8'h50, "R5 host 50");
    do_write(1'b0, 3'd0, 8'h52, 8'hFF); do_read(1'b0, 3'd0, 8'h52, "R5 host 52");
    do_write(1'b1, 3'd0, 8'h50, 8'hFF); do_read(1'b1, 3'd0, 8'h50, "R5 isa 50 full");
    do_write(1'b1, 3'd0, 8'h52, 8'hFF); do_read(1'b1, 3'd0, 8'h52, "R5 isa 52 full");

    // R6 full-byte offsets
    do_write(1'b0, 3'd0, 8'h40, 8'hA5); do_read(1'b0, 3'd0, 8'h40, "R6 full 40");
    do_write(1'b0, 3'd0, 8'h0C, 8'h3C); do_read(1'b0, 3'd0, 8'h0C, "R6 full 0C");

    // R7 absent functions
    do_write(1'b0, 3'd3, 8'h40, 8'h11);
    do_read(1'b0, 3'd0, 8'h40, "R7 write ignored");
    do_read(1'b0, 3'd3, 8'h40, "R7 read FF");
    do_read(1'b1, 3'd7, 8'h00, "R7 read FF");

    // R9 isolation
    do_write(1'b1, 3'd0, 8'h40, 8'h77);
    do_read(1'b0, 3'd0, 8'h40, "R9 host untouched");
    do_read(1'b1, 3'd0, 8'h40, "R9 isa written");

    // R10 same-cycle read and write
    do_rw(1'b0, 8'h60, 8'h9C, "R10 old value");
    do_read(1'b0, 3'd0, 8'h60, "R10 new value");
    do_rw(1'b1, 8'h05, 8'hFF, "R10 old value");
    do_read(1'b1, 3'd0, 8'h05, "R10 masked new");

    // sweep (R2..R6, R9)
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 256; o++) do_write(d[0], 3'd0, 8'(o), 8'(o) ^ (d ? 8'hC3 : 8'h5A));
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 256; o++) do_read(d[0], 3'd0, 8'(o), "R6 sweep");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R8 missing responses", 8'(q_exp.size()), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule